// File: doc/BRIEF.md
# Multi-cycle arithmetic stall controller

This block attaches a multi-cycle multiply/divide unit to a core that otherwise completes every instruction in one cycle. It recognises multiply and divide instructions, fires a one-cycle start pulse with a 2-bit operation code, and holds the program counter while the arithmetic unit is working. It also chooses which value goes to the register file: the ALU result or the selected half of the arithmetic unit's 64-bit result.

The core needs no hazard logic. The instruction under execution stays on `instr` because the program counter write enable is the inverse of busy. When the unit finishes, the PC advances and the register file is written exactly once.

The arithmetic unit is a stub inside the block. It is busy for `LATENCY` cycles and returns a tagged 64-bit value, which makes the control path checkable without a real multiplier or divider.

Top module: `mdu_stall_ctrl`

## Requirements
- R1: An instruction is an arithmetic-unit instruction when instr[6:0] == 7'b0110011 and instr[31:25] == 7'b0000001. `mul_div` is 1 exactly for such instructions.
- R2: `mc_op` = {instr[14], uns}. `uns` is 1 for funct3 (instr[14:12]) values 3'b011, 3'b101 and 3'b111, and 0 otherwise.
- R3: `mc_start` is 1 only in the first cycle an arithmetic-unit instruction is presented while the unit is idle. It is not 1 while the unit is busy, and it is not 1 in the cycle the result is written.
- R4: `pc_we` equals the inverse of `mc_busy`. `mc_busy` is 1 for exactly `LATENCY` consecutive cycles, starting with the start cycle.
- R5: For an arithmetic-unit instruction, `rf_we` is 1 only in the cycle after busy ends, which is the finishing cycle, and only once. For any other instruction, `rf_we` equals `reg_write_in`.
- R6: For any instruction that is not an arithmetic-unit instruction, `wb_data` equals `alu_result`.
- R7: In the finishing cycle, `wb_data` takes the low word of the result for funct3 3'b000, 3'b100 and 3'b101. It takes the high word for every other funct3 value.
- R8: The stub result uses the operands a = `rs1_val` and b = `rs2_val` as sampled in the start cycle. The low word is a + b + mc_op and the high word is a ^ b ^ {mc_op, 30'b0}. Operand changes after the start cycle have no effect.
- R9: After reset the unit is idle: `mc_busy` = 0, `pc_we` = 1, and no result is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 32 | Instruction at the current PC |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| alu_result | input | 32 | Single-cycle ALU result |
| reg_write_in | input | 1 | Register write request from the main decoder |
| mc_start | output | 1 | Start pulse to the arithmetic unit |
| mc_op | output | 2 | {divide, unsigned} operation code |
| mul_div | output | 1 | Writeback select: 1 picks the arithmetic unit |
| mc_busy | output | 1 | Arithmetic unit is working |
| pc_we | output | 1 | Program counter write enable |
| rf_we | output | 1 | Register file write enable |
| wb_data | output | 32 | Writeback value |

## Verification
The bench runs each of the eight funct3 codes. This separates the low-word and high-word selections and shows every operation code in the tagged result. It also runs plain register and immediate instructions and one with the arithmetic funct7 on a different opcode, which shows the decoder rejects near-misses. During each stall the operands and ALU value are changed, which shows the result comes from the values latched at start. After each arithmetic instruction a plain one follows, to catch a repeated start or a second write.

// File: rtl/mdu_stall_ctrl.sv
module mdu_stall_ctrl #(
  parameter int LATENCY = 4,
  parameter int XLEN    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] alu_result,
  input  logic            reg_write_in,
  output logic            mc_start,
  output logic [1:0]      mc_op,
  output logic            mul_div,
  output logic            mc_busy,
  output logic            pc_we,
  output logic            rf_we,
  output logic [XLEN-1:0] wb_data
);
  localparam int CW = $clog2(LATENCY + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(LATENCY);
  localparam logic [CW-1:0] CNT_ONE  = CW'(1);

  logic [2:0]      f3;
  logic            is_m, uns, hi_sel, done;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] res_lo, res_hi;

  assign f3      = instr[14:12];
  assign is_m    = (instr[6:0] == 7'b0110011) && (instr[31:25] == 7'b0000001);
  assign uns     = (f3 == 3'b011) || (f3 == 3'b101) || (f3 == 3'b111);
  assign mc_op   = {f3[2], uns};
  assign hi_sel  = !((f3 == 3'b000) || (f3 == 3'b100) || (f3 == 3'b101));
  assign mul_div = is_m;

  assign mc_start = is_m && (cnt == '0);
  assign done     = (cnt == CNT_ONE);
  assign mc_busy  = mc_start || (cnt > CNT_ONE);
  assign pc_we    = !mc_busy;
  assign rf_we    = is_m ? done : reg_write_in;
  assign wb_data  = !is_m ? alu_result : (hi_sel ? res_hi : res_lo);

  // Stub arithmetic unit: latches a tagged result, counts down the latency.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      res_lo <= '0;
      res_hi <= '0;
    end else if (mc_start) begin
      cnt    <= CNT_LOAD;
      res_lo <= rs1_val + rs2_val + XLEN'(mc_op);
      res_hi <= rs1_val ^ rs2_val ^ {mc_op, {(XLEN-2){1'b0}}};
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_ONE;
    end
  end

  p_start_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mc_start |=> !mc_start);
  p_busy_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mc_start |=> (mc_busy || rf_we));
  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mc_busy |-> !pc_we);
  p_single_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_m && rf_we) |=> !(is_m && rf_we));
  p_wb_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_m && rf_we) |-> (!mc_busy && !mc_start));
  p_alu_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mul_div |-> (wb_data == alu_result));
  p_reset_idle_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> !(mc_busy && !mc_start));
endmodule

// File: tb/mdu_stall_ctrl_tb.sv
module mdu_stall_ctrl_tb;
  localparam int LAT = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] instr = 32'h0, rs1_val = 32'h0, rs2_val = 32'h0, alu_result = 32'h0;
  logic reg_write_in = 1'b0;
  logic mc_start, mul_div, mc_busy, pc_we, rf_we;
  logic [1:0] mc_op;
  logic [31:0] wb_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mdu_stall_ctrl #(.LATENCY(LAT), .XLEN(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .alu_result(alu_result), .reg_write_in(reg_write_in), .mc_start(mc_start),
    .mc_op(mc_op), .mul_div(mul_div), .mc_busy(mc_busy), .pc_we(pc_we),
    .rf_we(rf_we), .wb_data(wb_data));

  // {funct7, funct3, opcode, a, b}
  localparam int NV = 11;
  localparam logic [80:0] VEC [NV] = '{
    {7'b0000001, 3'b000, 7'b0110011, 32'h12345678, 32'h9ABCDEF0},
    {7'b0000001, 3'b001, 7'b0110011, 32'hFFFFFFFF, 32'hFFFFFFFF},
    {7'b0000001, 3'b010, 7'b0110011, 32'h7FFFFFFF, 32'h00000002},
    {7'b0000001, 3'b011, 7'b0110011, 32'h80000000, 32'h00000002},
    {7'b0000001, 3'b100, 7'b0110011, 32'h00000005, 32'hFFFFFFFD},
    {7'b0000001, 3'b101, 7'b0110011, 32'hAAAAAAAA, 32'h00000002},
    {7'b0000001, 3'b110, 7'b0110011, 32'hFFFFFFFB, 32'h00000003},
    {7'b0000001, 3'b111, 7'b0110011, 32'h0000ABCD, 32'h00001234},
    {7'b0000000, 3'b000, 7'b0110011, 32'h00000001, 32'h00000002},
    {7'b0000001, 3'b000, 7'b0010011, 32'h00000003, 32'h00000004},
    {7'b0100000, 3'b000, 7'b0110011, 32'h00000006, 32'h00000007}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_result(input logic [2:0] f3, input logic [31:0] a, input logic [31:0] b);
    logic [1:0] op;
    logic hi;
    op = {f3[2], (f3 == 3'b011) || (f3 == 3'b101) || (f3 == 3'b111)};
    hi = !((f3 == 3'b000) || (f3 == 3'b100) || (f3 == 3'b101));
    return hi ? (a ^ b ^ {op, 30'b0}) : (a + b + {30'b0, op});
  endfunction

  task automatic plain_step(input logic [31:0] ins, input logic [31:0] alu, input logic rw, input string tag);
    @(negedge clk);
    instr = ins; alu_result = alu; reg_write_in = rw;
    #1;
    chk(mul_div == 1'b0, {tag, " R1 mul_div"}, 32'(mul_div), 32'h0);
    chk(mc_start == 1'b0 && pc_we == 1'b1, {tag, " R3/R4 no start"}, {30'b0, mc_start, pc_we}, 32'h1);
    chk(rf_we == rw, {tag, " R5 rf_we pass"}, 32'(rf_we), 32'(rw));
    chk(wb_data == alu, {tag, " R6 alu path"}, wb_data, alu);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(mc_busy == 1'b0 && pc_we == 1'b1, "R9 reset idle", {30'b0, mc_busy, pc_we}, 32'h1);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [6:0] f7, opc;
      logic [2:0] f3;
      logic [31:0] a, b, ins, expv;
      logic m;
      int stall, wbs;
      {f7, f3, opc, a, b} = VEC[i];
      ins = {f7, 5'd2, 5'd1, f3, 5'd3, opc};
      m = (opc == 7'b0110011) && (f7 == 7'b0000001);
      if (!m) begin
        plain_step(ins, a ^ 32'h5A5A0000, 1'b1, "plain");
        plain_step(ins, b, 1'b0, "plain rw0");
        continue;
      end
      expv = exp_result(f3, a, b);
      @(negedge clk);
      instr = ins; rs1_val = a; rs2_val = b; alu_result = 32'hDEAD0000; reg_write_in = 1'b1;
      #1;
      chk(mul_div == 1'b1, "R1 mul_div", 32'(mul_div), 32'h1);
      chk(mc_start == 1'b1, "R3 start first cycle", 32'(mc_start), 32'h1);
      chk(mc_op == {f3[2], (f3 == 3'b011) || (f3 == 3'b101) || (f3 == 3'b111)}, "R2 op code",
          32'(mc_op), 32'({f3[2], (f3 == 3'b011) || (f3 == 3'b101) || (f3 == 3'b111)}));
      chk(rf_we == 1'b0, "R5 no early write", 32'(rf_we), 32'h0);
      stall = 0; wbs = 0;
      for (int c = 0; c < LAT + 3; c++) begin
        if (c > 0) begin
          @(negedge clk);
          rs1_val = ~a; rs2_val = b + 32'd77; alu_result = 32'hBEEF0000 + 32'(c);
          #1;
          if (mc_start) chk(1'b0, "R3 repeated start", 32'h1, 32'h0);
        end
        if (!pc_we) stall++;
        if (pc_we != !mc_busy) chk(1'b0, "R4 pc_we vs busy", 32'(pc_we), 32'(!mc_busy));
        if (rf_we) begin
          wbs++;
          chk(stall == LAT, "R4 stall length", 32'(stall), 32'(LAT));
          chk(wb_data == expv, "R7/R8 result", wb_data, expv);
          break;
        end
      end
      chk(wbs == 1, "R5 one writeback", 32'(wbs), 32'h1);
      plain_step(32'h00208033, 32'h13579BDF, 1'b0, "after M");
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule